// File: doc/BRIEF.md
# Doubleword ECC Line Checker (72/64)

This block checks the error-correcting code of a cache line as it streams past. A line is four 64-bit doublewords, each paired with the 8-bit check byte that was stored with it. For every beat the block generates the eight check bits from the data. It compares them with the stored byte and sorts a mismatch into one of two classes: a single-bit error or a multi-bit error. Each check bit is the parity of a masked subset of the data bits. The eight masks are one 64-bit pattern rotated a byte further for each successive check bit.

Across a line the block collects a 4-bit mask of the doublewords that failed, plus sticky single-error and double-error flags. One cycle after the fourth beat is accepted it raises a one-cycle done pulse, and the final mask and flags are visible in that cycle. The block detects and classifies only; it never corrects data. The freshly generated check byte of the beat on the input is also driven out combinationally, so the generator can be tested on its own.

Top module: `ecc_line_checker`

## Requirements
- R1: `calc_chk_o` bit i equals the XOR of the bits of `data_i` selected by mask i, in the same cycle. Mask 0 is 64'h0738C808099264FF, and mask i is mask 0 rotated left by 8*i bits.
- R2: A beat is bad when its syndrome (`calc_chk_o` XOR `chk_i`) is nonzero. A beat with a zero syndrome leaves the mask bit for its position clear.
- R3: A bad beat whose syndrome has exactly one bit set sets `sbe_o`.
- R4: A bad beat whose syndrome has two or more bits set sets `dbe_o`. `sbe_o` or `dbe_o` is never high while `bad_mask_o` is zero.
- R5: Accepted beats take offsets 0,1,2,3 in order. A bad beat at offset k sets bit 3-k of `bad_mask_o`, so offset 0 maps to bit 3.
- R6: Within a line, the mask bits and flags only accumulate. The beat at offset 0 starts from a cleared mask and cleared flags.
- R7: `done_o` is high for exactly one cycle: the cycle after the clock edge that accepts the offset-3 beat. In that cycle `bad_mask_o`, `sbe_o` and `dbe_o` show the whole line, and they hold until the next beat, start or reset.
- R8: `start_i` clears the mask and the flags and returns the offset to 0. A beat presented in the same cycle is taken as offset 0 of the new line.
- R9: Synchronous reset `rst` clears the mask, the flags and the offset, and holds `done_o` low.
- R10: While `valid_i` and `start_i` are low, `data_i` and `chk_i` are ignored: the mask, flags and offset do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a new line; clears collected state |
| valid_i | input | 1 | A doubleword beat is present |
| data_i | input | 64 | Doubleword data |
| chk_i | input | 8 | Stored check byte of the doubleword |
| calc_chk_o | output | 8 | Check byte generated from `data_i` |
| bad_mask_o | output | 4 | Doublewords with bad ECC, offset k at bit 3-k |
| sbe_o | output | 1 | A single-bit error was seen in the line |
| dbe_o | output | 1 | A multi-bit error was seen in the line |
| done_o | output | 1 | One-cycle pulse after the fourth beat |

## Verification
On every cycle, the assertions check the following: the done pulse lasts one cycle and always follows an offset-3 beat; flags never exist without a mask bit; flags stay set within a line; and idle or start-only cycles leave the state held or cleared. The values themselves can only be shown by the bench's scenarios. These include the generated check byte against an independently computed parity, the single/multi split over all 256 syndromes, the mapping of offset to mask bit over every bad-beat pattern, and the behaviour of start and reset partway through a line.

// File: rtl/ecc_line_pkg.sv
package ecc_line_pkg;

    localparam int unsigned WORD_W    = 64;
    localparam int unsigned CODE_W    = 8;
    localparam int unsigned LINE_LEN  = 4;
    localparam logic [63:0] SEED_MASK = 64'h0738C808099264FF;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_SINGLE = 2'd1,
        ERR_MULTI  = 2'd2
    } err_kind_e;

    // Parity-select mask for check bit idx: seed rotated left by one byte per index.
    function automatic logic [63:0] sel_mask(int unsigned idx);
        logic [127:0] twice;
        logic [127:0] shifted;
        twice   = {SEED_MASK, SEED_MASK};
        shifted = twice >> (64 - 8 * (idx % 8));
        return shifted[63:0];
    endfunction

endpackage

// File: rtl/ecc_check_gen.sv
module ecc_check_gen
    import ecc_line_pkg::*;
#(
    parameter int unsigned DW = WORD_W,
    parameter int unsigned CW = CODE_W
) (
    input  logic [DW-1:0] data_i,
    output logic [CW-1:0] code_o
);
    // One XOR tree per check bit; the mask picks its inputs.
    for (genvar i = 0; i < CW; i++) begin : g_bit
        localparam logic [63:0] MASK_FULL = sel_mask(i);
        localparam logic [DW-1:0] MASK    = MASK_FULL[DW-1:0];
        assign code_o[i] = ^(data_i & MASK);
    end
endmodule

// File: rtl/ecc_syndrome_class.sv
module ecc_syndrome_class
    import ecc_line_pkg::*;
#(
    parameter int unsigned CW = CODE_W
) (
    input  logic [CW-1:0] calc_i,
    input  logic [CW-1:0] stored_i,
    output err_kind_e     kind_o
);
    localparam int unsigned CNT_W = $clog2(CW + 1);

    logic [CW-1:0]    syn;
    logic [CNT_W-1:0] ones;

    always_comb begin
        syn  = calc_i ^ stored_i;
        ones = '0;
        for (int b = 0; b < CW; b++) begin
            ones = ones + CNT_W'(syn[b]);
        end
        if (syn == '0) begin
            kind_o = ERR_NONE;
        end else if (ones == CNT_W'(1)) begin
            kind_o = ERR_SINGLE;
        end else begin
            kind_o = ERR_MULTI;
        end
    end
endmodule

// File: rtl/ecc_line_accum.sv
module ecc_line_accum
    import ecc_line_pkg::*;
#(
    parameter int unsigned BEATS = LINE_LEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             valid_i,
    input  err_kind_e        kind_i,
    output logic [BEATS-1:0] bad_mask_o,
    output logic             sbe_o,
    output logic             dbe_o,
    output logic             done_o
);
    localparam int unsigned OFS_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [OFS_W-1:0] LAST = OFS_W'(BEATS - 1);

    typedef struct packed {
        logic [OFS_W-1:0] ofs;
        logic [BEATS-1:0] bad;
        logic             sbe;
        logic             dbe;
        logic             done;
    } acc_t;

    acc_t             st_d, st_q;
    logic [OFS_W-1:0] pos_d;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        pos_d     = st_q.ofs;
        if (start_i) begin
            pos_d    = '0;
            st_d.ofs = '0;
            st_d.bad = '0;
            st_d.sbe = 1'b0;
            st_d.dbe = 1'b0;
        end
        if (valid_i) begin
            if (pos_d == '0) begin
                st_d.bad = '0;
                st_d.sbe = 1'b0;
                st_d.dbe = 1'b0;
            end
            if (kind_i != ERR_NONE) begin
                st_d.bad[BEATS - 1 - int'(pos_d)] = 1'b1;
            end
            if (kind_i == ERR_SINGLE) st_d.sbe = 1'b1;
            if (kind_i == ERR_MULTI)  st_d.dbe = 1'b1;
            if (pos_d == LAST) begin
                st_d.ofs  = '0;
                st_d.done = 1'b1;
            end else begin
                st_d.ofs = pos_d + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bad_mask_o = st_q.bad;
    assign sbe_o      = st_q.sbe;
    assign dbe_o      = st_q.dbe;
    assign done_o     = st_q.done;

    // R7
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.done |=> !st_q.done);

    // R7
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.done |-> $past(valid_i && !start_i && st_q.ofs == LAST));

    // R4
    flags_need_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.sbe || st_q.dbe) |-> (st_q.bad != '0));

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ((st_q.sbe || st_q.dbe) && !start_i && !(valid_i && st_q.ofs == '0))
        |=> (st_q.sbe || st_q.dbe));

    // R8
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !valid_i) |=> (st_q.bad == '0 && !st_q.sbe && !st_q.dbe && st_q.ofs == '0));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid_i && !start_i) |=> ($stable(st_q.bad) && $stable(st_q.sbe)
                                    && $stable(st_q.dbe) && $stable(st_q.ofs)));
endmodule

// File: rtl/ecc_line_checker.sv
module ecc_line_checker
    import ecc_line_pkg::*;
#(
    parameter int unsigned DW    = WORD_W,
    parameter int unsigned CW    = CODE_W,
    parameter int unsigned BEATS = LINE_LEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             valid_i,
    input  logic [DW-1:0]    data_i,
    input  logic [CW-1:0]    chk_i,
    output logic [CW-1:0]    calc_chk_o,
    output logic [BEATS-1:0] bad_mask_o,
    output logic             sbe_o,
    output logic             dbe_o,
    output logic             done_o
);
    err_kind_e beat_kind;

    ecc_check_gen #(.DW(DW), .CW(CW)) u_gen (
        .data_i (data_i),
        .code_o (calc_chk_o)
    );

    ecc_syndrome_class #(.CW(CW)) u_cls (
        .calc_i   (calc_chk_o),
        .stored_i (chk_i),
        .kind_o   (beat_kind)
    );

    ecc_line_accum #(.BEATS(BEATS)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .valid_i    (valid_i),
        .kind_i     (beat_kind),
        .bad_mask_o (bad_mask_o),
        .sbe_o      (sbe_o),
        .dbe_o      (dbe_o),
        .done_o     (done_o)
    );
endmodule

// File: tb/ecc_line_checker_test.sv
`timescale 1ns/1ps
module ecc_line_checker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        valid_i = 1'b0;
    logic [63:0] data_i = '0;
    logic [7:0]  chk_i = '0;
    logic [7:0]  calc_chk_o;
    logic [3:0]  bad_mask_o;
    logic        sbe_o, dbe_o, done_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    ecc_line_checker uut (
        .clk(clk), .rst(rst), .start_i(start_i), .valid_i(valid_i),
        .data_i(data_i), .chk_i(chk_i), .calc_chk_o(calc_chk_o),
        .bad_mask_o(bad_mask_o), .sbe_o(sbe_o), .dbe_o(dbe_o), .done_o(done_o)
    );

    // Expected check byte: parity of data under each written-out mask.
    function automatic logic [7:0] ref_code(logic [63:0] d);
        logic [63:0] m [8];
        logic [7:0]  r;
        m[0] = 64'h0738C808099264FF; m[1] = 64'h38C808099264FF07;
        m[2] = 64'hC808099264FF0738; m[3] = 64'h08099264FF0738C8;
        m[4] = 64'h099264FF0738C808; m[5] = 64'h9264FF0738C80809;
        m[6] = 64'h64FF0738C8080992; m[7] = 64'hFF0738C808099264;
        for (int i = 0; i < 8; i++) begin
            r[i] = 1'b0;
            for (int b = 0; b < 64; b++) r[i] = r[i] ^ (d[b] & m[i][b]);
        end
        return r;
    endfunction

    function automatic logic [63:0] pat(int n);
        return {32'(n) * 32'h9E3779B9, ~(32'(n) * 32'h85EBCA6B)};
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_up();
        end
    end

    task automatic beat(logic [63:0] d, logic [7:0] err, bit st);
        @(negedge clk);
        valid_i = 1'b1; start_i = st; data_i = d; chk_i = ref_code(d) ^ err;
    endtask

    task automatic idle();
        @(negedge clk);
        valid_i = 1'b0; start_i = 1'b0;
    endtask

    // Sends a full line with per-beat error syndromes and checks the result.
    task automatic line(int seed, logic [7:0] e0, logic [7:0] e1, logic [7:0] e2,
                        logic [7:0] e3, string tag);
        logic [7:0] e [4];
        logic [3:0] xm;
        bit xs, xd;
        e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
        xm = '0; xs = 0; xd = 0;
        for (int k = 0; k < 4; k++) begin
            if (e[k] != 0) xm[3-k] = 1'b1;
            if ($countones(e[k]) == 1) xs = 1;
            if ($countones(e[k]) > 1)  xd = 1;
            beat(pat(seed + k), e[k], 1'b0);
        end
        idle();
        check(done_o == 1'b1, {tag, " R7 done"}, 64'(done_o), 64'd1);
        check(bad_mask_o == xm, {tag, " R5 mask"}, 64'(bad_mask_o), 64'(xm));
        check(sbe_o == xs, {tag, " R3 sbe"}, 64'(sbe_o), 64'(xs));
        check(dbe_o == xd, {tag, " R4 dbe"}, 64'(dbe_o), 64'(xd));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        @(negedge clk);
        check(bad_mask_o == 0 && !sbe_o && !dbe_o && !done_o, "R9 reset state",
              {bad_mask_o, sbe_o, dbe_o, done_o}, 64'd0);

        // R1: generator, walking one and pseudo-random data
        for (int b = 0; b < 64; b++) begin
            @(negedge clk); data_i = 64'd1 << b; #1;
            check(calc_chk_o == ref_code(data_i), "R1 walk", 64'(calc_chk_o), 64'(ref_code(data_i)));
        end
        for (int n = 0; n < 64; n++) begin
            @(negedge clk); data_i = pat(n); #1;
            check(calc_chk_o == ref_code(data_i), "R1 rand", 64'(calc_chk_o), 64'(ref_code(data_i)));
        end
        // R10: ignored inputs while idle left mask clear
        check(bad_mask_o == 0, "R10 idle", 64'(bad_mask_o), 64'd0);

        // R2/R3/R4: all 256 syndromes, moved across offsets
        for (int s = 0; s < 256; s++) begin
            logic [7:0] e [4];
            for (int k = 0; k < 4; k++) e[k] = (k == s % 4) ? 8'(s) : 8'd0;
            line(s * 7, e[0], e[1], e[2], e[3], "R2 syndrome");
        end
        // R7: done lasts one cycle; results held
        idle();
        check(done_o == 1'b0, "R7 pulse width", 64'(done_o), 64'd0);

        // R5/R6: every bad-beat pattern, mixed error kinds
        for (int p = 0; p < 16; p++) begin
            logic [7:0] e [4];
            for (int k = 0; k < 4; k++)
                e[k] = p[3-k] ? (((p + k) % 3 == 0) ? 8'h11 : 8'h40 >> k) : 8'd0;
            line(1000 + p, e[0], e[1], e[2], e[3], "R6 pattern");
        end

        // R10: idle with garbage between beats changes nothing
        beat(pat(1), 8'h00, 1'b0);
        beat(pat(2), 8'h02, 1'b0);
        @(negedge clk); valid_i = 0; data_i = 64'hDEAD; chk_i = 8'h5A;
        repeat (3) @(negedge clk);
        check(bad_mask_o == 4'b0100 && sbe_o && !dbe_o && !done_o, "R10 hold",
              {bad_mask_o, sbe_o, dbe_o, done_o}, {4'b0100, 3'b100});
        beat(pat(3), 8'h00, 1'b0);
        beat(pat(4), 8'h00, 1'b0);
        idle();
        check(done_o && bad_mask_o == 4'b0100, "R10 finish",
              {bad_mask_o, done_o}, {4'b0100, 1'b1});

        // R8: start mid-line; the start beat is offset 0
        beat(pat(5), 8'h03, 1'b0);
        beat(pat(6), 8'h03, 1'b0);
        beat(pat(7), 8'h80, 1'b1);
        beat(pat(8), 8'h00, 1'b0);
        beat(pat(9), 8'h00, 1'b0);
        idle();
        check(!done_o && bad_mask_o == 4'b1000 && sbe_o && !dbe_o, "R8 restart",
              {bad_mask_o, sbe_o, dbe_o, done_o}, {4'b1000, 3'b100});
        beat(pat(10), 8'h00, 1'b0);
        idle();
        check(done_o && bad_mask_o == 4'b1000, "R8 done", {bad_mask_o, done_o}, {4'b1000, 1'b1});

        // R8: start alone clears
        @(negedge clk); start_i = 1'b1;
        idle();
        check(bad_mask_o == 0 && !sbe_o && !dbe_o, "R8 clear",
              {bad_mask_o, sbe_o, dbe_o}, 64'd0);

        // R9: reset mid-line
        beat(pat(11), 8'h0F, 1'b0);
        beat(pat(12), 8'h00, 1'b0);
        @(negedge clk); valid_i = 0; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(bad_mask_o == 0 && !dbe_o && !done_o, "R9 mid reset",
              {bad_mask_o, dbe_o, done_o}, 64'd0);
        line(2000, 8'h00, 8'h00, 8'h00, 8'h01, "R9 after reset");

        finish_up();
    end
endmodule